// File: doc/BRIEF.md
# Handshaked Byte-Stream Readout Port

This block lets an external controller pull an undecoded compressed audio stream out of the chip as parallel bytes. Upstream logic delivers bytes with a valid strobe and a marker on the byte that opens a frame header. The port waits for the first marker, then collects bytes into fixed blocks of `BLOCK_BYTES` (16 by default). The marker byte is stored as byte 0 of a block, so the first bit of the header appears on bus line 7.

The controller checks that the end-of-block flag is high and then raises its request line. The request is synchronized and acted on at its rising edge. Each request puts the next byte on the bus and then drives a low strobe pulse `STROBE_CYCLES` clocks long. Sixteen exchanges move the block. A seventeenth request moves no byte and raises the end-of-block flag again. If a new block finishes filling before the old one has been fully read, the old one is dropped and a sticky overrun flag is set. The port is enabled by a configuration bit. While that bit is clear, the bus is not driven.

Top module: `byte_readout_port`

## Requirements
- R1: After reset, `blk_end` is 1, `rd_strobe_n` is 1, `overrun` is 0 and `rd_data` is 0.
- R2: Bytes that arrive before the first byte marked with `src_hdr` are discarded. The marked byte becomes byte 0 of the first block, with its bit 7 on `rd_data[7]`.
- R3: A marked byte that arrives while a block is part-filled discards the partial bytes and restarts the fill with itself as byte 0.
- R4: Each serviced request updates `rd_data` and then holds `rd_strobe_n` low for exactly `STROBE_CYCLES` clocks, with `rd_data` stable for the whole low period.
- R5: A block is delivered as exactly `BLOCK_BYTES` strobes, in the order the bytes arrived.
- R6: `blk_end` falls when the first request of a block is serviced and stays low through all byte strobes. The request after the last byte produces no strobe and sets `blk_end` to 1.
- R7: A request that arrives while no block is buffered is remembered. Its first byte is strobed as soon as a block becomes available.
- R8: If a block completes while the buffered block is not fully read, the buffered block is dropped, `overrun` is set and `blk_end` returns to 1. The next read then starts at byte 0 of the new block.
- R9: While `mode_en` is 0: `bus_oe` is 0, `rd_data` is 0, `rd_strobe_n` is 1, requests and upstream bytes are discarded, and header alignment must be found again after re-enabling.
- R10: Once set, `overrun` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Configuration bit that enables the readout port |
| src_data | input | 8 | Upstream stream byte |
| src_valid | input | 1 | `src_data` holds a byte this cycle |
| src_hdr | input | 1 | This byte begins a frame header |
| ctl_req | input | 1 | Controller request line (asynchronous) |
| rd_data | output | 8 | Parallel byte bus, bit 7 first in the stream |
| rd_strobe_n | output | 1 | Low pulse: `rd_data` holds a valid byte |
| blk_end | output | 1 | High between blocks; low while a block is in transfer |
| overrun | output | 1 | Sticky: a buffered block was overwritten |
| bus_oe | output | 1 | Bus and strobe are driven |

## Verification
Sixteen consecutive blocks together carry every 8-bit value once, so a lost, repeated or reordered byte is detected. The sweep mixes blocks that open with a marker and blocks that continue an existing lock, which separates realignment from plain block counting. Separate patterns are used for the remaining cases, and each has a distinct visible result:
- junk before the first marker;
- a marker in the middle of a fill;
- a request made before any data arrives;
- overruns against both an untouched block and a half-read one;
- a stream sent while the port is disabled.

// File: rtl/rdo_pkg.sv
// Shared types for the byte readout port.
// Assumes: nothing beyond IEEE 1800-2017.
package rdo_pkg;

    // Readout sequencer states.
    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,  // between blocks, end-of-block flag high
        RD_STROBE = 2'd1,  // strobe low, byte on bus
        RD_WAIT   = 2'd2   // strobe done, waiting for next request
    } rd_state_t;

endpackage

// File: rtl/rdo_req_sync.sv
// Synchronizes the controller's asynchronous request line into the clock
// domain and emits a one-cycle pulse on each rising edge.
// Assumes: STAGES >= 2; the request stays high for longer than STAGES+1 clocks.
module rdo_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Flop chain: stage 0 samples the raw line, each later stage the previous one.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= req_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Delay of the synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign req_rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/rdo_block_fill.sv
// Collects upstream bytes into blocks of BYTES. It locks onto the first byte
// marked as a header start, and every later marker restarts the fill at index 0.
// It gives a one-cycle load pulse the clock after a block completes; the
// block contents stay valid during that pulse.
// Assumes: BYTES >= 2; enable low clears the lock and the fill position.
module rdo_block_fill #(
    parameter int BYTES = 16,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DW-1:0]     src_data,
    input  logic              src_valid,
    input  logic              src_hdr,
    output logic [BYTES*DW-1:0] blk_flat,
    output logic              blk_load
);

    localparam int IW = $clog2(BYTES);

    logic [DW-1:0] fill_q [BYTES];
    logic          locked_q;
    logic [IW-1:0] wr_idx_q;
    logic          take;

    assign take = enable && src_valid && (src_hdr || locked_q);

    // Lock, fill position and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            wr_idx_q <= '0;
            blk_load <= 1'b0;
        end else begin
            blk_load <= 1'b0;
            if (!enable) begin
                locked_q <= 1'b0;
                wr_idx_q <= '0;
            end else if (src_valid) begin
                if (src_hdr) begin
                    locked_q <= 1'b1;
                    wr_idx_q <= IW'(1);
                end else if (locked_q) begin
                    if (wr_idx_q == IW'(BYTES - 1)) begin
                        wr_idx_q <= '0;
                        blk_load <= 1'b1;
                    end else begin
                        wr_idx_q <= wr_idx_q + IW'(1);
                    end
                end
            end
        end
    end

    // Byte storage; a marker byte always lands at index 0.
    always_ff @(posedge clk) begin
        if (take) fill_q[src_hdr ? IW'(0) : wr_idx_q] <= src_data;
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_flat
        assign blk_flat[g*DW +: DW] = fill_q[g];
    end

endmodule

// File: rtl/rdo_readout_fsm.sv
// Holds one complete block and serves it to the controller with one byte per
// request edge. Each byte is followed by a low strobe of STROBE_CYCLES clocks.
// The request after the last byte closes the block. A new block that arrives
// while the buffer is still occupied replaces it and sets the sticky overrun flag.
// Assumes: blk_flat is stable during blk_load; request edges that arrive
// while the strobe is low are ignored.
module rdo_readout_fsm
    import rdo_pkg::*;
#(
    parameter int BYTES         = 16,
    parameter int DW            = 8,
    parameter int STROBE_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                req_rise,
    input  logic                blk_load,
    input  logic [BYTES*DW-1:0] blk_flat,
    output logic [DW-1:0]       rd_data_q,
    output logic                strobe_n_q,
    output logic                blk_end,
    output logic                overrun_q
);

    localparam int AW = $clog2(BYTES);
    localparam int IW = $clog2(BYTES + 1);
    localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;

    rd_state_t     state_q;
    logic [DW-1:0] buf_q [BYTES];
    logic          full_q;
    logic          pend_q;
    logic [IW-1:0] idx_q;
    logic [CW-1:0] scnt_q;
    logic          last_req;
    logic          overrun_evt;
    logic          start_ok;

    assign last_req    = (state_q == RD_WAIT) && req_rise && (idx_q == IW'(BYTES));
    assign overrun_evt = blk_load && full_q && !last_req;
    assign start_ok    = full_q && (req_rise || pend_q);
    assign blk_end     = (state_q == RD_IDLE);

    // Block buffer: takes a complete block from the fill stage.
    always_ff @(posedge clk) begin
        if (enable && blk_load) begin
            for (int i = 0; i < BYTES; i++) buf_q[i] <= blk_flat[i*DW +: DW];
        end
    end

    // Sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n)           overrun_q <= 1'b0;
        else if (enable && overrun_evt) overrun_q <= 1'b1;
    end

    // Handshake sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q    <= RD_IDLE;
            full_q     <= 1'b0;
            pend_q     <= 1'b0;
            idx_q      <= '0;
            scnt_q     <= '0;
            strobe_n_q <= 1'b1;
            rd_data_q  <= '0;
        end else if (blk_load) begin
            state_q    <= RD_IDLE;
            full_q     <= 1'b1;
            idx_q      <= '0;
            strobe_n_q <= 1'b1;
            pend_q     <= (state_q == RD_IDLE) && !full_q && (pend_q || req_rise);
        end else begin
            case (state_q)
                RD_IDLE: begin
                    if (start_ok) begin
                        rd_data_q  <= buf_q[0];
                        strobe_n_q <= 1'b0;
                        scnt_q     <= CW'(STROBE_CYCLES - 1);
                        idx_q      <= IW'(1);
                        pend_q     <= 1'b0;
                        state_q    <= RD_STROBE;
                    end else if (req_rise) begin
                        pend_q <= 1'b1;
                    end
                end
                RD_STROBE: begin
                    if (scnt_q == '0) begin
                        strobe_n_q <= 1'b1;
                        state_q    <= RD_WAIT;
                    end else begin
                        scnt_q <= scnt_q - CW'(1);
                    end
                end
                RD_WAIT: begin
                    if (last_req) begin
                        full_q  <= 1'b0;
                        idx_q   <= '0;
                        state_q <= RD_IDLE;
                    end else if (req_rise) begin
                        rd_data_q  <= buf_q[idx_q[AW-1:0]];
                        strobe_n_q <= 1'b0;
                        scnt_q     <= CW'(STROBE_CYCLES - 1);
                        idx_q      <= idx_q + IW'(1);
                        state_q    <= RD_STROBE;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/byte_readout_port.sv
// Top level of the handshaked byte readout port: request synchronizer,
// block fill stage and readout sequencer. While mode_en is low the bus is
// released: data is forced to 0, the strobe is held high and bus_oe is low.
// Assumes: synchronous active-low reset; ctl_req may be asynchronous.
module byte_readout_port #(
    parameter int BLOCK_BYTES   = 16,
    parameter int DATA_W        = 8,
    parameter int STROBE_CYCLES = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    input  logic              src_hdr,
    input  logic              ctl_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_strobe_n,
    output logic              blk_end,
    output logic              overrun,
    output logic              bus_oe
);

    logic                        req_rise;
    logic [BLOCK_BYTES*DATA_W-1:0] blk_flat;
    logic                        blk_load;
    logic [DATA_W-1:0]           data_q;
    logic                        strobe_q;

    rdo_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (ctl_req),
        .req_rise  (req_rise)
    );

    rdo_block_fill #(.BYTES(BLOCK_BYTES), .DW(DATA_W)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mode_en),
        .src_data  (src_data),
        .src_valid (src_valid),
        .src_hdr   (src_hdr),
        .blk_flat  (blk_flat),
        .blk_load  (blk_load)
    );

    rdo_readout_fsm #(
        .BYTES(BLOCK_BYTES), .DW(DATA_W), .STROBE_CYCLES(STROBE_CYCLES)
    ) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (mode_en),
        .req_rise   (req_rise),
        .blk_load   (blk_load),
        .blk_flat   (blk_flat),
        .rd_data_q  (data_q),
        .strobe_n_q (strobe_q),
        .blk_end    (blk_end),
        .overrun_q  (overrun)
    );

    // Bus release while the port is disabled.
    assign rd_data     = mode_en ? data_q : '0;
    assign rd_strobe_n = mode_en ? strobe_q : 1'b1;
    assign bus_oe      = mode_en;

endmodule

// File: rtl/rdo_checker.sv
// Protocol checks on the readout port's pins, attached by bind.
// Assumes: the same parameters as the bound instance.
module rdo_checker #(
    parameter int BYTES         = 16,
    parameter int DW            = 8,
    parameter int STROBE_CYCLES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_en,
    input logic [DW-1:0] rd_data,
    input logic          rd_strobe_n,
    input logic          blk_end,
    input logic          overrun
);

    logic [15:0] low_len;
    logic [15:0] fall_cnt;
    logic        prev_strobe;

    // Counts consecutive low strobe cycles seen before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n || rd_strobe_n) low_len <= '0;
        else                       low_len <= low_len + 16'd1;
    end

    // Counts strobe pulses in the current block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_strobe <= 1'b1;
            fall_cnt    <= '0;
        end else begin
            prev_strobe <= rd_strobe_n;
            if (blk_end)                          fall_cnt <= '0;
            else if (prev_strobe && !rd_strobe_n) fall_cnt <= fall_cnt + 16'd1;
        end
    end

    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_n |-> (low_len < 16'(STROBE_CYCLES)));

    assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe_n && $past(!rd_strobe_n) && $past(mode_en)) |-> $stable(rd_data));

    assert_strobe_in_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_n |-> !blk_end);

    assert_byte_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt <= 16'(BYTES));

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overrun) |-> overrun);

    assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> blk_end);

endmodule

bind byte_readout_port rdo_checker #(
    .BYTES(BLOCK_BYTES), .DW(DATA_W), .STROBE_CYCLES(STROBE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_en     (mode_en),
    .rd_data     (rd_data),
    .rd_strobe_n (rd_strobe_n),
    .blk_end     (blk_end),
    .overrun     (overrun)
);

// File: tb/byte_readout_port_test.sv
// Self-checking bench: byte sweep over 16 blocks plus alignment, pending,
// overrun and disable scenarios.
module byte_readout_port_test;

    localparam int NB = 16;
    localparam int SC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b1;
    logic [7:0] src_data = '0;
    logic       src_valid = 1'b0;
    logic       src_hdr = 1'b0;
    logic       ctl_req = 1'b0;
    logic [7:0] rd_data;
    logic       rd_strobe_n;
    logic       blk_end;
    logic       overrun;
    logic       bus_oe;

    always #4 clk = ~clk;

    byte_readout_port #(.BLOCK_BYTES(NB), .STROBE_CYCLES(SC)) uut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
        .src_data(src_data), .src_valid(src_valid), .src_hdr(src_hdr),
        .ctl_req(ctl_req), .rd_data(rd_data), .rd_strobe_n(rd_strobe_n),
        .blk_end(blk_end), .overrun(overrun), .bus_oe(bus_oe)
    );

    int         checks = 0;
    int         errors = 0;
    logic [7:0] cap [256];
    int         cap_n = 0;
    int         base = 0;
    int         low_cnt = 0;
    logic       prev_s = 1'b1;
    logic [7:0] exp_blk [NB];
    bit         done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Strobe monitor: captures bytes on the falling strobe and measures its width.
    always @(negedge clk) begin
        if (rst_n && mode_en) begin
            if (prev_s && !rd_strobe_n) begin
                cap[cap_n[7:0]] <= rd_data;
                cap_n   <= cap_n + 1;
                low_cnt <= 1;
            end else if (!rd_strobe_n) begin
                low_cnt <= low_cnt + 1;
            end else if (!prev_s) begin
                check(low_cnt == SC, "R4 strobe width", low_cnt, SC);
            end
        end
        prev_s <= rd_strobe_n;
    end

    task automatic send_byte(input logic [7:0] d, input bit hdr);
        @(negedge clk);
        src_data  = d;
        src_hdr   = hdr;
        src_valid = 1'b1;
    endtask

    task automatic send_block(input bit marker);
        for (int i = 0; i < NB; i++) send_byte(exp_blk[i], marker && (i == 0));
        @(negedge clk);
        src_valid = 1'b0;
        src_hdr   = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk);
        ctl_req = 1'b1;
        repeat (10) @(negedge clk);
        ctl_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Reads the rest of the block from the current capture base and closes it.
    task automatic read_block(input string tag);
        for (int i = cap_n - base; i < NB; i++) begin
            pulse_req();
            if (i == 0) check(blk_end == 1'b0, "R6 flag low after first request", blk_end, 0);
        end
        check(blk_end == 1'b0, "R6 flag low before closing request", blk_end, 0);
        pulse_req();
        check(blk_end == 1'b1, "R6 flag high after closing request", blk_end, 1);
        check(cap_n - base == NB, "R5 strobes per block", cap_n - base, NB);
        for (int i = 0; i < NB; i++)
            check(cap[8'(base + i)] == exp_blk[i], tag, cap[8'(base + i)], exp_blk[i]);
        base = cap_n;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(blk_end == 1'b1, "R1 blk_end", blk_end, 1);
        check(rd_strobe_n == 1'b1, "R1 strobe", rd_strobe_n, 1);
        check(overrun == 1'b0, "R1 overrun", overrun, 0);
        check(rd_data == 8'h00, "R1 data", rd_data, 0);
        check(bus_oe == 1'b1, "R1 bus_oe", bus_oe, 1);

        // R2 junk before the first marker is dropped
        for (int j = 0; j < 5; j++) send_byte(8'hE0 + 8'(j), 1'b0);
        // Sweep: 16 blocks together cover all 256 byte values
        for (int b = 0; b < 16; b++) begin
            for (int i = 0; i < NB; i++) exp_blk[i] = 8'(b * 16 + i) ^ 8'h3C;
            send_block((b == 0) || (b % 3 == 1));
            read_block(b == 0 ? "R2 first block after lock" : "R5 sweep byte");
        end

        // R3 marker mid-fill restarts the block
        send_byte(8'h11, 1'b0);
        send_byte(8'h22, 1'b0);
        send_byte(8'h33, 1'b1);
        for (int j = 0; j < 4; j++) send_byte(8'h40 + 8'(j), 1'b0);
        for (int i = 0; i < NB; i++) exp_blk[i] = 8'h80 + 8'(i * 5);
        send_block(1'b1);
        read_block("R3 realigned byte");

        // R7 request before data is held
        pulse_req();
        check(cap_n == base, "R7 no strobe without data", cap_n - base, 0);
        check(blk_end == 1'b1, "R7 flag stays high", blk_end, 1);
        for (int i = 0; i < NB; i++) exp_blk[i] = ~8'(i * 17);
        send_block(1'b0);
        repeat (10) @(negedge clk);
        check(cap_n - base == 1, "R7 held request served", cap_n - base, 1);
        check(cap[8'(base)] == exp_blk[0], "R7 first byte", cap[8'(base)], exp_blk[0]);
        read_block("R7 byte");

        // R8 overrun against an untouched block
        check(overrun == 1'b0, "R8 no overrun yet", overrun, 0);
        for (int i = 0; i < NB; i++) exp_blk[i] = 8'h01 << (i % 8);
        send_block(1'b0);
        for (int i = 0; i < NB; i++) exp_blk[i] = 8'hF0 - 8'(i);
        send_block(1'b0);
        check(overrun == 1'b1, "R8 overrun set", overrun, 1);
        read_block("R8 newer block byte");

        // R8 overrun against a half-read block
        for (int i = 0; i < NB; i++) exp_blk[i] = 8'h55;
        send_block(1'b0);
        for (int k = 0; k < 3; k++) pulse_req();
        check(blk_end == 1'b0, "R8 mid transfer", blk_end, 0);
        for (int i = 0; i < NB; i++) exp_blk[i] = 8'hA0 ^ 8'(i);
        send_block(1'b0);
        check(blk_end == 1'b1, "R8 flag back high", blk_end, 1);
        base = cap_n;
        read_block("R8 replacing block byte");
        check(overrun == 1'b1, "R10 overrun sticky", overrun, 1);

        // R9 disabled port
        @(negedge clk);
        mode_en = 1'b0;
        @(negedge clk);
        check(bus_oe == 1'b0, "R9 bus_oe", bus_oe, 0);
        check(rd_strobe_n == 1'b1, "R9 strobe", rd_strobe_n, 1);
        check(rd_data == 8'h00, "R9 data", rd_data, 0);
        pulse_req();
        for (int i = 0; i < NB; i++) exp_blk[i] = 8'h77;
        send_block(1'b1);
        check(cap_n == base, "R9 no strobe while off", cap_n - base, 0);
        mode_en = 1'b1;
        repeat (2) @(negedge clk);
        pulse_req();
        check(cap_n == base, "R9 block sent while off dropped", cap_n - base, 0);
        for (int j = 0; j < 3; j++) send_byte(8'h99, 1'b0);
        for (int i = 0; i < NB; i++) exp_blk[i] = 8'(i * 3 + 1);
        send_block(1'b1);
        repeat (10) @(negedge clk);
        read_block("R9 relocked block byte");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule